// File: doc/BRIEF.md
# Runtime-Partitioned SIMD Adder

This block is a 32-bit adder whose carry chain can be broken at any bit position chosen while the chip runs. A partition mask register holds one bit per data bit. When a packed add is requested, every set mask bit k stops the carry from entering bit k. That bit then becomes the least significant bit of a new element. Packed elements can therefore have any widths, and the widths may differ inside one word: for example two 5/6/5 colour pixels in one word, or a 7-bit field next to a 25-bit one.

A plain add ignores the mask and carries through all 32 bits. Each packed element wraps modulo its own width, and its carry-out is thrown away. Software loads the mask through a single-cycle write port and can read it back at any time. The sum leaves through one register stage together with a valid flag.

Top module: `part_add_top`

## Requirements
- R1: After reset the partition mask reads 0, outValid is 0 and outSum is 0.
- R2: A cycle with maskWrEn high loads maskWrData into the mask. maskRdData shows the new value from the next cycle on and holds it until the next write.
- R3: With opPacked = 0 the result is (opA + opB) mod 2^32, whatever value the mask holds.
- R4: With opPacked = 1, each set mask bit k (k ≥ 1) blocks the carry into bit k. Each element runs from one boundary up to the bit below the next boundary (or up to bit 31). Each element's sum is the element-wise sum modulo 2^width.
- R5: A packed add with mask bits 31..1 all zero equals a plain add, and mask bit 0 never changes a result.
- R6: With mask 0x08210820 (bits 5, 11, 16, 21, 27 set), a packed add performs two independent 5/6/5 additions on fields 4..0, 10..5, 15..11, 20..16, 26..21 and 31..27.
- R7: An operation sampled with inValid high at a rising edge appears on outSum with outValid high just after that edge. A cycle sampled with inValid low gives outValid low and leaves outSum unchanged.
- R8: An operation presented in the same cycle as a mask write uses the mask value from before the write.
- R9: With an all-ones mask, a packed add returns opA XOR opB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| maskWrEn | input | 1 | Write strobe for the partition mask |
| maskWrData | input | 32 | New partition mask value |
| maskRdData | output | 32 | Current partition mask |
| inValid | input | 1 | Operands and opcode are valid this cycle |
| opPacked | input | 1 | 1 = packed add using the mask, 0 = plain add |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| outValid | output | 1 | outSum holds a new result |
| outSum | output | 32 | Registered sum |

## Verification
Each sum is due exactly one rising edge after the operation is sampled. A mask write becomes visible on maskRdData one edge after the strobe. It affects only operations sampled at later edges, never an operation sampled at the same edge as the write. The driver changes inputs on falling edges and, at that moment, pushes an expected value taken from an element-by-element reference model, using the mask that the design will apply. The monitor pops one entry on every falling edge that finds outValid high, which is half a cycle after the result was registered. On every falling edge where outValid is low, it checks that outSum has held.

// File: rtl/part_add_pkg.sv
package part_add_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic capture;     // register a new result at this edge
    logic packedMode;  // honour the cut vector
  } addStrobe_t;

endpackage

// File: rtl/part_add_chain.sv
// Bit-serial carry chain whose carry-in can be cut at any bit
module part_add_chain #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] cutVec,
  output logic [DATA_W-1:0] sumOut
);

  logic [DATA_W-1:0] carryRaw;
  logic [DATA_W-1:0] carryEff;
  logic [DATA_W-1:0] propBit;
  logic [DATA_W-1:0] genBit;

  assign carryRaw[0] = 1'b0;
  assign propBit     = opA ^ opB;
  assign genBit      = opA & opB;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    // a cut bit makes this position the LSB of a new element
    assign carryEff[i] = carryRaw[i] & ~cutVec[i];
    assign sumOut[i]   = propBit[i] ^ carryEff[i];
    if (i < DATA_W - 1) begin : g_carry
      assign carryRaw[i+1] = genBit[i] | (propBit[i] & carryEff[i]);
    end
  end

endmodule

// File: rtl/part_add_ctrl.sv
// Control: partition mask register and per-cycle strobes
module part_add_ctrl
  import part_add_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              maskWrEn,
  input  logic [DATA_W-1:0] maskWrData,
  input  logic              inValid,
  input  logic              opPacked,
  output logic [DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0] cutVec,
  output addStrobe_t        strobe
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (maskWrEn) begin
      maskQ <= maskWrData;
    end
  end

  always_comb begin
    strobe.capture    = inValid;
    strobe.packedMode = opPacked;
    // the old mask applies to an op presented with a write
    cutVec = opPacked ? maskQ : '0;
  end

endmodule

// File: rtl/part_add_dp.sv
// Datapath: segmented adder plus one output register stage
module part_add_dp
  import part_add_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  addStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] cutVec,
  output logic              outValid,
  output logic [DATA_W-1:0] outSum
);

  logic [DATA_W-1:0] sumComb;
  logic [DATA_W-1:0] cutGated;

  assign cutGated = strobe.packedMode ? cutVec : '0;

  part_add_chain #(.DATA_W(DATA_W)) chainInst (
    .opA   (opA),
    .opB   (opB),
    .cutVec(cutGated),
    .sumOut(sumComb)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSum   <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        outSum <= sumComb;
      end
    end
  end

endmodule

// File: rtl/part_add_top.sv
module part_add_top
  import part_add_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              maskWrEn,
  input  logic [DATA_W-1:0] maskWrData,
  output logic [DATA_W-1:0] maskRdData,
  input  logic              inValid,
  input  logic              opPacked,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] outSum
);

  addStrobe_t        strobe;
  logic [DATA_W-1:0] cutVec;

  part_add_ctrl #(.DATA_W(DATA_W)) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .maskWrEn  (maskWrEn),
    .maskWrData(maskWrData),
    .inValid   (inValid),
    .opPacked  (opPacked),
    .maskQ     (maskRdData),
    .cutVec    (cutVec),
    .strobe    (strobe)
  );

  part_add_dp #(.DATA_W(DATA_W)) dpInst (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .cutVec  (cutVec),
    .outValid(outValid),
    .outSum  (outSum)
  );

endmodule

// File: rtl/part_add_chk.sv
module part_add_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              maskWrEn,
  input logic [DATA_W-1:0] maskWrData,
  input logic [DATA_W-1:0] maskRdData,
  input logic              inValid,
  input logic              opPacked,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              outValid,
  input logic [DATA_W-1:0] outSum
);

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskWrEn |=> maskRdData == $past(maskWrData));

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !maskWrEn |=> $stable(maskRdData));

  // R3
  plain_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opPacked) |=> outSum == $past(opA + opB));

  // R5
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opPacked && maskRdData[DATA_W-1:1] == '0)
      |=> outSum == $past(opA + opB));

  // R9
  full_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opPacked && maskRdData == '1) |=> outSum == $past(opA ^ opB));

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outSum)));

endmodule

bind part_add_top part_add_chk #(.DATA_W(DATA_W)) chkInst (
  .clk       (clk),
  .rstN      (rstN),
  .maskWrEn  (maskWrEn),
  .maskWrData(maskWrData),
  .maskRdData(maskRdData),
  .inValid   (inValid),
  .opPacked  (opPacked),
  .opA       (opA),
  .opB       (opB),
  .outValid  (outValid),
  .outSum    (outSum)
);

// File: tb/tb_part_add_top.sv
module tb_part_add_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam logic [W-1:0] RGB_MASK = 32'h0821_0820;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         maskWrEn = 1'b0;
  logic [W-1:0] maskWrData = '0;
  logic [W-1:0] maskRdData;
  logic         inValid = 1'b0;
  logic         opPacked = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         outValid;
  logic [W-1:0] outSum;

  typedef struct {
    logic [W-1:0] expVal;
    string        tag;
  } item_t;

  item_t        sbQueue[$];
  logic [W-1:0] maskModel = '0;
  logic [W-1:0] lastSum = '0;
  int           checks = 0;
  int           failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  part_add_top #(.DATA_W(W)) dut (
    .clk(clk), .rstN(rstN), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .maskRdData(maskRdData), .inValid(inValid), .opPacked(opPacked),
    .opA(opA), .opB(opB), .outValid(outValid), .outSum(outSum)
  );

  // reference: add each element on its own
  function automatic logic [W-1:0] refSum(logic [W-1:0] a, logic [W-1:0] b,
                                          logic pk, logic [W-1:0] m);
    logic [W-1:0] res = '0;
    int lo = 0;
    if (!pk) return a + b;
    for (int i = 1; i <= W; i++) begin
      if (i == W || m[i]) begin
        logic [63:0] fm;
        logic [63:0] s;
        fm = (64'd1 << (i - lo)) - 64'd1;
        s = ((({32'd0, a} >> lo) & fm) + (({32'd0, b} >> lo) & fm)) & fm;
        res = res | W'(s << lo);
        lo = i;
      end
    end
    return res;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic issue(logic [W-1:0] a, logic [W-1:0] b, logic pk, string tag);
    item_t it;
    @(negedge clk);
    maskWrEn = 1'b0;
    inValid = 1'b1; opPacked = pk; opA = a; opB = b;
    it.expVal = refSum(a, b, pk, maskModel);
    it.tag = tag;
    sbQueue.push_back(it);
  endtask

  task automatic issueLit(logic [W-1:0] a, logic [W-1:0] b, logic pk,
                          logic [W-1:0] lit, string tag);
    item_t it;
    @(negedge clk);
    maskWrEn = 1'b0;
    inValid = 1'b1; opPacked = pk; opA = a; opB = b;
    it.expVal = lit;
    it.tag = tag;
    sbQueue.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; maskWrEn = 1'b0;
    end
  endtask

  task automatic writeMask(logic [W-1:0] m);
    @(negedge clk);
    inValid = 1'b0; maskWrEn = 1'b1; maskWrData = m;
    @(negedge clk);
    maskWrEn = 1'b0;
    maskModel = m;
    check("R2 mask readback", maskRdData, m);
  endtask

  // R8: op and mask write in the same cycle
  task automatic writeWithOp(logic [W-1:0] m, logic [W-1:0] a, logic [W-1:0] b);
    item_t it;
    @(negedge clk);
    maskWrEn = 1'b1; maskWrData = m;
    inValid = 1'b1; opPacked = 1'b1; opA = a; opB = b;
    it.expVal = refSum(a, b, 1'b1, maskModel);
    it.tag = "R8 old mask used";
    sbQueue.push_back(it);
    @(negedge clk);
    maskWrEn = 1'b0; inValid = 1'b0;
    maskModel = m;
    check("R8 mask updated", maskRdData, m);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (outValid) begin
          if (sbQueue.size() == 0) begin
            checks++; failures++;
            $display("FAIL R7 unexpected result actual=%h expected=none", outSum);
          end else begin
            item_t it;
            it = sbQueue.pop_front();
            check(it.tag, outSum, it.expVal);
          end
          lastSum = outSum;
        end else begin
          check("R7 idle hold", outSum, lastSum);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 mask reset", maskRdData, '0);
    check("R1 valid reset", {31'd0, outValid}, '0);
    check("R1 sum reset", outSum, '0);
    idle(1);

    // R5 zero mask packed equals plain
    issue(32'hFFFF_FFFF, 32'h0000_0001, 1'b1, "R5 zero mask");
    issue(32'h1234_5678, 32'h0FED_CBA9, 1'b1, "R5 zero mask");
    idle(2);
    writeMask(32'h0000_0001);
    issueLit(32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 32'h0, "R5 bit0 ignored");

    // R6 RGB565
    writeMask(RGB_MASK);
    issueLit(32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 32'hFFFF_FFE0, "R6 low field wrap");
    issueLit(32'hFFFF_FFFF, 32'h0821_0821, 1'b1, 32'h0, "R6 all fields wrap");
    issue(32'hA5C3_7E19, 32'h5B2E_96F4, 1'b1, "R6 pixels");
    // R3 plain ignores mask
    issueLit(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0, "R3 plain");
    issue(32'h8765_4321, 32'h789A_BCDF, 1'b0, "R3 plain");
    idle(3);

    // R9 all ones
    writeMask('1);
    issueLit(32'hF0F0_1234, 32'hFFFF_0F0F, 1'b1, 32'h0F0F_1D3B, "R9 xor");

    // R8
    writeWithOp(32'h0001_0000, 32'h0000_FFFF, 32'h0000_0001);
    issueLit(32'h0000_FFFF, 32'h0000_0001, 1'b1, 32'h0, "R8 new mask");
    idle(2);

    // R4 random masks, mixed ops and gaps
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] m;
      m = $urandom();
      if (n % 7 == 0) m = m & $urandom();
      writeMask(m);
      for (int k = 0; k < 4; k++) begin
        issue($urandom(), $urandom(), (k != 3), "R4 random");
      end
      if (n % 3 == 0) idle(1);
    end

    idle(4);
    check("R7 queue drained", W'(sbQueue.size()), '0);
    finishRun();
  end

endmodule